// File: doc/BRIEF.md
# Stereo Serial Audio Port (I2S / Left-Justified)

This block moves stereo PCM samples between two small FIFOs and a three-wire serial audio link made of a bit clock, a frame clock and one data line per direction. The clocks come from outside and are treated as slow levels sampled by the block's own system clock. One direction is active at a time. In transmit the block shifts out words taken from the transmit FIFO. In receive it shifts in words and pushes them into the receive FIFO.

The framing is set by a small group of configuration inputs: the direction, a one-bit data delay (I2S when set, left-justified when clear), an inversion of the bit-clock edge, the frame-clock level that marks the left channel, and a word-length code. The first FIFO access in the selected direction arms the port. It then starts at the next left-channel frame edge and runs whole stereo pairs until the enable input is dropped. A transmit FIFO that runs dry and a receive FIFO that is full each set a sticky error flag. The flags feed one gated interrupt and are cleared by a strobe that carries a bit mask.

Top module: `sap_port`

## Requirements
- R1: With the delay bit set, the MSB of each word is driven in the second bit slot of its channel. Bits go out MSB first, and every slot outside the word carries 0.
- R2: With the delay bit clear, the MSB is driven in the first bit slot of the channel, the slot that begins at the frame-clock transition.
- R3: With bit-clock inversion clear, data is launched on the falling bit-clock edge and sampled on the rising edge. With inversion set, the two edges swap roles.
- R4: With frame polarity 0, frame clock low marks the left channel; with polarity 1, high marks it. The first word after start always goes in a left slot, and words then alternate left, right.
- R5: Word-length code 0 selects 16 bits, 4 selects 20 and 8 selects 24. Data is right-justified in the 24-bit FIFO word, and transmit bits above the word length are ignored. Any other code keeps the port from starting, so busy stays 0.
- R6: With the read-mode bit set, the received bits of each word are assembled MSB first into a right-justified FIFO word, left before right. Line values outside the word's slots are ignored.
- R7: While the enable is high, the first transmit write (transmit mode) or receive read (receive mode) raises busy on the next clock. Busy stays high until the enable is low at a left-channel frame edge. Busy falls there, after a complete stereo pair.
- R8: Configuration inputs are captured only while busy is low. Changes made while busy have no effect on the running transfer.
- R9: If the transmit FIFO is empty when a channel slot begins, that slot sends all zeros and the sticky underflow flag is set.
- R10: A received word that finds the receive FIFO full is dropped, and the sticky overflow flag is set. The words already stored are kept.
- R11: A clear strobe resets the underflow flag when mask bit 0 is set and the overflow flag when mask bit 1 is set. A flag whose mask bit is 0 is unchanged.
- R12: The interrupt output is high exactly when the interrupt enable is high and at least one error flag is set.
- R13: The serial data output is 0 whenever the port is idle or in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock level |
| fclk_in | input | 1 | Frame (channel select) clock level |
| sdata_in | input | 1 | Serial receive data |
| sdata_out | output | 1 | Serial transmit data |
| port_en | input | 1 | Allows start; low stops at the next left edge |
| cfg_rx_mode | input | 1 | 0 transmit, 1 receive |
| cfg_i2s_delay | input | 1 | 1 one-bit data delay (I2S), 0 left-justified |
| cfg_bclk_inv | input | 1 | Swap launch and sample bit-clock edges |
| cfg_fclk_pol | input | 1 | Frame-clock level that marks the left channel |
| cfg_word_code | input | 4 | Word length code: 0=16, 4=20, 8=24 bits |
| err_irq_en | input | 1 | Interrupt enable for the error flags |
| tx_wr_en | input | 1 | Push tx_wr_data into the transmit FIFO |
| tx_wr_data | input | 24 | Transmit sample, right-justified |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd_en | input | 1 | Pop the receive FIFO head |
| rx_rd_data | output | 24 | Receive FIFO head, right-justified |
| rx_empty | output | 1 | Receive FIFO empty |
| err_clr_wr | input | 1 | Clear strobe for the error flags |
| err_clr_bits | input | 2 | Clear mask: bit 0 underflow, bit 1 overflow |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| err_irq | output | 1 | Error interrupt |
| busy | output | 1 | Transfer armed or active |

## Verification
The assertions assume that the bit clock and frame clock are slow against the system clock: each level is held for several system cycles, and the frame clock changes only together with a launch edge. They also assume that every channel slot is at least one bit longer than the word plus the delay. The bench builds its links from eight-cycle bit periods, changes the frame clock only on launch edges, and uses 28-bit slots, so every word fits with padding around it. Configuration inputs are changed while busy only in the test that shows they are ignored.

// File: rtl/sap_pkg.sv
// Package: shared types and helpers of the serial audio port.
// Assumes the widest supported audio word is 24 bits.
package sap_pkg;

    localparam int SAP_MAXW = 24;

    // Latched framing configuration, frozen while the port is busy.
    typedef struct packed {
        logic       rx_mode;
        logic       i2s_delay;
        logic       bclk_inv;
        logic       fclk_pol;
        logic [3:0] word_code;
    } sap_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } sap_state_t;

    // Word length in bits for a code; 0 marks an unsupported code.
    function automatic logic [4:0] sap_word_bits(input logic [3:0] code);
        case (code)
            4'd0:    return 5'd16;
            4'd4:    return 5'd20;
            4'd8:    return 5'd24;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/sap_fifo.sv
// Module: sap_fifo - small synchronous first-word-fall-through FIFO.
// Writes to a full FIFO and reads from an empty one are ignored.
// Assumes DEPTH is a power of two, at least 2.
module sap_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr_q, rptr_q;

    assign empty   = (wptr_q == rptr_q);
    assign full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
    assign rd_data = mem[rptr_q[AW-1:0]];

    // Pointer update for accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_en && !full)  wptr_q <= wptr_q + 1'b1;
            if (rd_en && !empty) rptr_q <= rptr_q + 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wptr_q[AW-1:0]] <= wr_data;
    end

endmodule

// File: rtl/sap_edge_det.sv
// Module: sap_edge_det - samples the serial link into the system clock domain
// and marks the launch and sample edges of the bit clock.
// Assumes the link is much slower than clk and the frame clock moves only with
// a launch edge, so one register stage is enough to capture it.
module sap_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fclk_in,
    input  logic sdata_in,
    input  logic bclk_inv,
    output logic launch,
    output logic sample,
    output logic fclk_lvl,
    output logic sdi_lvl
);
    logic bclk_q, bclk_d, fclk_q, sdi_q;
    logic eff_now, eff_old;

    // Capture the link levels and keep one older bit-clock copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            bclk_d <= 1'b0;
            fclk_q <= 1'b0;
            sdi_q  <= 1'b0;
        end else begin
            bclk_q <= bclk_in;
            bclk_d <= bclk_q;
            fclk_q <= fclk_in;
            sdi_q  <= sdata_in;
        end
    end

    // Effective bit clock: its falling edge launches, its rising edge samples.
    always_comb begin
        eff_now = bclk_q ^ bclk_inv;
        eff_old = bclk_d ^ bclk_inv;
        sample  = eff_now & ~eff_old;
        launch  = ~eff_now & eff_old;
    end

    assign fclk_lvl = fclk_q;
    assign sdi_lvl  = sdi_q;

endmodule

// File: rtl/sap_serdes.sv
// Module: sap_serdes - bit-slot counter plus transmit and receive shifters.
// Counts bit slots from each frame-clock change, places the word after the
// optional one-slot delay, pads with zeros and collects received bits.
// Assumes each slot is longer than word length plus delay.
module sap_serdes
    import sap_pkg::*;
#(
    parameter int SLOT_MAX = 63
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                sample,
    input  logic                fclk_lvl,
    input  logic                sdi_lvl,
    input  sap_cfg_t            cfg,
    input  logic [4:0]          wbits,
    input  logic                chan_start,
    input  logic [SAP_MAXW-1:0] tx_word,
    input  logic                tx_avail,
    output logic                boundary,
    output logic                left_edge,
    output logic                sdo,
    output logic                tx_pop,
    output logic                tx_starve,
    output logic                rx_push,
    output logic [SAP_MAXW-1:0] rx_word
);
    localparam int CW = $clog2(SLOT_MAX + 1);
    localparam int PW = CW + 1;

    logic [CW-1:0]       cnt_q, cnt_nx;
    logic                fclk_prev_q, live_q, live_nx, sdo_q;
    logic [SAP_MAXW-1:0] tword_q, rword_q, word_nx, aligned, rx_next;
    logic [PW-1:0]       pos_tx, pos_rx;
    logic [4:0]          tx_idx;
    logic                tx_dir, load, tx_hit, rx_hit, rx_last;

    // Slot bookkeeping and the next transmit bit.
    always_comb begin
        boundary  = launch & (fclk_lvl != fclk_prev_q);
        left_edge = boundary & (fclk_lvl == cfg.fclk_pol);
        cnt_nx    = boundary ? '0 : ((cnt_q == CW'(SLOT_MAX)) ? cnt_q : cnt_q + 1'b1);
        live_nx   = boundary ? chan_start : live_q;
        tx_dir    = ~cfg.rx_mode;
        load      = chan_start & tx_dir;
        aligned   = tx_word << (5'(SAP_MAXW) - wbits);
        word_nx   = load ? (tx_avail ? aligned : '0) : tword_q;
        pos_tx    = PW'(cnt_nx) - PW'(cfg.i2s_delay);
        tx_hit    = live_nx & tx_dir & (cnt_nx >= CW'(cfg.i2s_delay)) & (pos_tx < PW'(wbits));
        tx_idx    = 5'(SAP_MAXW - 1) - pos_tx[4:0];
    end

    // Receive position within the current slot.
    always_comb begin
        pos_rx  = PW'(cnt_q) - PW'(cfg.i2s_delay);
        rx_hit  = live_q & cfg.rx_mode & (cnt_q >= CW'(cfg.i2s_delay)) & (pos_rx < PW'(wbits));
        rx_last = ((pos_rx + 1'b1) == PW'(wbits));
        rx_next = {rword_q[SAP_MAXW-2:0], sdi_lvl};
    end

    assign tx_pop    = load & tx_avail;
    assign tx_starve = load & ~tx_avail;
    assign rx_push   = sample & rx_hit & rx_last;
    assign rx_word   = rx_next;
    assign sdo       = sdo_q;

    // Advance slot state on launch edges and shift in on sample edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            fclk_prev_q <= 1'b0;
            live_q      <= 1'b0;
            tword_q     <= '0;
            rword_q     <= '0;
            sdo_q       <= 1'b0;
        end else if (launch) begin
            cnt_q       <= cnt_nx;
            fclk_prev_q <= fclk_lvl;
            live_q      <= live_nx;
            tword_q     <= word_nx;
            sdo_q       <= tx_hit ? word_nx[tx_idx] : 1'b0;
            if (chan_start) rword_q <= '0;
        end else if (sample && rx_hit) begin
            rword_q <= rx_next;
        end
    end

endmodule

// File: rtl/sap_port.sv
// Module: sap_port - stereo serial audio port, top level.
// Latches configuration while idle, arms on the first FIFO access, runs whole
// stereo pairs from a left-channel frame edge, and keeps sticky FIFO error
// flags with a gated interrupt. Assumes externally generated link clocks.
module sap_port
    import sap_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SLOT_MAX   = 63
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                fclk_in,
    input  logic                sdata_in,
    output logic                sdata_out,
    input  logic                port_en,
    input  logic                cfg_rx_mode,
    input  logic                cfg_i2s_delay,
    input  logic                cfg_bclk_inv,
    input  logic                cfg_fclk_pol,
    input  logic [3:0]          cfg_word_code,
    input  logic                err_irq_en,
    input  logic                tx_wr_en,
    input  logic [SAP_MAXW-1:0] tx_wr_data,
    output logic                tx_full,
    input  logic                rx_rd_en,
    output logic [SAP_MAXW-1:0] rx_rd_data,
    output logic                rx_empty,
    input  logic                err_clr_wr,
    input  logic [1:0]          err_clr_bits,
    output logic                tx_underflow,
    output logic                rx_overflow,
    output logic                err_irq,
    output logic                busy
);
    sap_cfg_t            cfg_in, cfg_q;
    sap_state_t          state_q, state_nx;
    logic [4:0]          wbits;
    logic                start_req, chan_start;
    logic                launch, sample, fclk_lvl, sdi_lvl;
    logic                boundary, left_edge;
    logic                tx_pop, tx_starve, rx_push;
    logic [SAP_MAXW-1:0] tx_head, rx_word;
    logic                tx_empty_i, rx_full_i;
    logic                uf_q, of_q;

    assign cfg_in = '{rx_mode:   cfg_rx_mode,
                      i2s_delay: cfg_i2s_delay,
                      bclk_inv:  cfg_bclk_inv,
                      fclk_pol:  cfg_fclk_pol,
                      word_code: cfg_word_code};
    assign wbits  = sap_word_bits(cfg_q.word_code);

    sap_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_in  (bclk_in),
        .fclk_in  (fclk_in),
        .sdata_in (sdata_in),
        .bclk_inv (cfg_q.bclk_inv),
        .launch   (launch),
        .sample   (sample),
        .fclk_lvl (fclk_lvl),
        .sdi_lvl  (sdi_lvl)
    );

    sap_serdes #(.SLOT_MAX(SLOT_MAX)) u_serdes (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .sample     (sample),
        .fclk_lvl   (fclk_lvl),
        .sdi_lvl    (sdi_lvl),
        .cfg        (cfg_q),
        .wbits      (wbits),
        .chan_start (chan_start),
        .tx_word    (tx_head),
        .tx_avail   (~tx_empty_i),
        .boundary   (boundary),
        .left_edge  (left_edge),
        .sdo        (sdata_out),
        .tx_pop     (tx_pop),
        .tx_starve  (tx_starve),
        .rx_push    (rx_push),
        .rx_word    (rx_word)
    );

    sap_fifo #(.W(SAP_MAXW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tx_wr_en),
        .wr_data (tx_wr_data),
        .rd_en   (tx_pop),
        .rd_data (tx_head),
        .full    (tx_full),
        .empty   (tx_empty_i)
    );

    sap_fifo #(.W(SAP_MAXW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_push),
        .wr_data (rx_word),
        .rd_en   (rx_rd_en),
        .rd_data (rx_rd_data),
        .full    (rx_full_i),
        .empty   (rx_empty)
    );

    // Start request: first access in the chosen direction with a valid code.
    always_comb begin
        start_req = port_en && (sap_word_bits(cfg_in.word_code) != 5'd0) &&
                    (cfg_in.rx_mode ? rx_rd_en : tx_wr_en);
        chan_start = boundary &&
                     (((state_q == ST_RUN) && !(left_edge && !port_en)) ||
                      ((state_q == ST_ARMED) && left_edge && port_en));
    end

    // Next-state logic of the transfer controller.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_IDLE:  if (start_req) state_nx = ST_ARMED;
            ST_ARMED: if (!port_en) state_nx = ST_IDLE;
                      else if (left_edge) state_nx = ST_RUN;
            ST_RUN:   if (left_edge && !port_en) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Controller state and configuration capture while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE) cfg_q <= cfg_in;
        end
    end

    // Sticky error flags; a new event wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q <= 1'b0;
            of_q <= 1'b0;
        end else begin
            uf_q <= (uf_q && !(err_clr_wr && err_clr_bits[0])) || tx_starve;
            of_q <= (of_q && !(err_clr_wr && err_clr_bits[1])) || (rx_push && rx_full_i);
        end
    end

    assign tx_underflow = uf_q;
    assign rx_overflow  = of_q;
    assign err_irq      = err_irq_en && (uf_q || of_q);
    assign busy         = (state_q != ST_IDLE);

endmodule

// File: rtl/sap_port_checker.sv
// Module: sap_port_checker - protocol properties of sap_port, bound to it.
// Assumes the link timing described in the brief.
module sap_port_checker
    import sap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input sap_cfg_t   cfg_q,
    input logic       sdata_out,
    input logic       tx_underflow,
    input logic       rx_overflow,
    input logic       err_irq,
    input logic       err_irq_en,
    input logic       err_clr_wr,
    input logic [1:0] err_clr_bits,
    input logic       tx_empty_i,
    input logic       rx_full_i
);
    // R8: captured configuration holds while the port stays busy.
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_q));

    // R9: underflow is only raised while the transmit FIFO was empty.
    p_uf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_underflow) |-> $past(tx_empty_i));

    // R10: overflow is only raised while the receive FIFO was full.
    p_of_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overflow) |-> $past(rx_full_i));

    // R11: a set flag persists unless its own clear bit is written.
    p_uf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underflow && !(err_clr_wr && err_clr_bits[0])) |=> tx_underflow);

    p_of_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !(err_clr_wr && err_clr_bits[1])) |=> rx_overflow);

    // R12: no interrupt without the enable, and a flag with the enable raises it.
    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !err_irq_en |-> !err_irq);

    p_irq_raise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq_en && (tx_underflow || rx_overflow)) |-> err_irq);

    // R13: the data line stays low when idle or receiving.
    p_sdo_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || cfg_q.rx_mode) |-> !sdata_out);

endmodule

bind sap_port sap_port_checker u_sap_port_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .cfg_q        (cfg_q),
    .sdata_out    (sdata_out),
    .tx_underflow (tx_underflow),
    .rx_overflow  (rx_overflow),
    .err_irq      (err_irq),
    .err_irq_en   (err_irq_en),
    .err_clr_wr   (err_clr_wr),
    .err_clr_bits (err_clr_bits),
    .tx_empty_i   (tx_empty_i),
    .rx_full_i    (rx_full_i)
);

// File: tb/sap_port_bench.sv
// Bench: directed scenarios; the bench plays the codec side of the link.
module sap_port_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n, bclk, fclk, sdi, sdo;
    logic        port_en, cfg_rx, cfg_dly, cfg_inv, cfg_pol, irq_en;
    logic [3:0]  cfg_code;
    logic        tx_wr_en, tx_full, rx_rd_en, rx_empty, clr_wr;
    logic [23:0] tx_wr_data, rx_rd_data;
    logic [1:0]  clr_bits;
    logic        uf, of, irq, busy;

    int nchk = 0, nfail = 0;
    bit done = 0;
    int m_rx, m_dly, m_inv, m_pol, m_len, padbad, sdo_ones;
    localparam int SLOT = 28;
    logic [23:0] txw [8];
    logic [23:0] rxw [8];
    logic [23:0] cap [8];

    always #5 clk = ~clk;

    sap_port u_sap_port (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fclk_in(fclk),
        .sdata_in(sdi), .sdata_out(sdo), .port_en(port_en),
        .cfg_rx_mode(cfg_rx), .cfg_i2s_delay(cfg_dly), .cfg_bclk_inv(cfg_inv),
        .cfg_fclk_pol(cfg_pol), .cfg_word_code(cfg_code), .err_irq_en(irq_en),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .err_clr_wr(clr_wr), .err_clr_bits(clr_bits),
        .tx_underflow(uf), .rx_overflow(of), .err_irq(irq), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mask(input int len);
        return (24'h1 << len) - 24'h1;
    endfunction

    // Set format inputs, bench model and reset the block.
    task automatic setfmt(input int rx, input int dly, input int inv, input int pol, input int code);
        m_rx = rx; m_dly = dly; m_inv = inv; m_pol = pol;
        m_len = (code == 0) ? 16 : (code == 4) ? 20 : 24;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_rx = 1'(rx); cfg_dly = 1'(dly); cfg_inv = 1'(inv); cfg_pol = 1'(pol);
        cfg_code = 4'(code);
        bclk = ~1'(inv); fclk = ~1'(pol); sdi = 1'b0;
        port_en = 1'b1; irq_en = 1'b0; tx_wr_en = 1'b0; tx_wr_data = '0;
        rx_rd_en = 1'b0; clr_wr = 1'b0; clr_bits = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input logic [23:0] w);
        tx_wr_en = 1'b1; tx_wr_data = w;
        @(negedge clk);
        tx_wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop(output logic [23:0] w);
        w = rx_rd_data;
        rx_rd_en = 1'b1;
        @(negedge clk);
        rx_rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] bits);
        clr_wr = 1'b1; clr_bits = bits;
        @(negedge clk);
        clr_wr = 1'b0;
        @(negedge clk);
    endtask

    // One bit period: launch half then sample half (R3 edge roles from m_inv).
    task automatic bit_cycle(input logic lvl, input logic d, output logic s);
        fclk = lvl; bclk = 1'(m_inv); sdi = d;
        repeat (4) @(negedge clk);
        s = sdo;
        bclk = ~1'(m_inv);
        repeat (4) @(negedge clk);
    endtask

    // Lead-in right slot, nfr stereo frames, then a left edge; enable drops in the last right slot.
    task automatic play(input int nfr);
        logic s;
        logic left = 1'(m_pol);
        padbad = 0; sdo_ones = 0;
        for (int i = 0; i < 8; i++) cap[i] = '0;
        for (int b = 0; b < 4; b++) bit_cycle(~left, 1'b0, s);
        for (int f = 0; f < nfr; f++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int b = 0; b < SLOT; b++) begin
                    int idx = f * 2 + ch;
                    int p = b - m_dly;
                    bit inw = (p >= 0) && (p < m_len);
                    logic d = inw ? rxw[idx][m_len-1-p] : 1'b1;
                    if (f == nfr - 1 && ch == 1 && b == 0) port_en = 1'b0;
                    bit_cycle(ch == 0 ? left : ~left, d, s);
                    if (s) sdo_ones++;
                    if (inw) cap[idx][m_len-1-p] = s;
                    else if (s) padbad++;
                end
            end
        end
        bit_cycle(left, 1'b0, s);
        bit_cycle(left, 1'b0, s);
    endtask

    task automatic t_tx_i2s();
        setfmt(0, 1, 0, 0, 4);
        chk("R7 reset busy", busy, 0);
        chk("R9 reset underflow", uf, 0);
        chk("R13 reset sdo", sdo, 0);
        for (int i = 0; i < 4; i++) push(txw[i]);
        chk("R7 busy after write", busy, 1);
        cfg_dly = 1'b0; cfg_code = 4'd0; cfg_pol = 1'b1;
        play(2);
        for (int i = 0; i < 4; i++) chk("R1/R5/R8 i2s 20-bit word", cap[i], txw[i] & mask(20));
        chk("R1 zero padding", padbad, 0);
        chk("R7 busy after stop", busy, 0);
        chk("R9 no underflow", uf, 0);
    endtask

    task automatic t_tx_lj();
        setfmt(0, 0, 1, 1, 0);
        for (int i = 0; i < 4; i++) push(txw[i + 4]);
        play(2);
        for (int i = 0; i < 4; i++) chk("R2/R3/R4 lj inverted 16-bit word", cap[i], txw[i + 4] & mask(16));
        chk("R2 zero padding", padbad, 0);
    endtask

    task automatic t_unsup();
        setfmt(0, 1, 0, 0, 2);
        push(txw[0]);
        chk("R5 unsupported code no start", busy, 0);
    endtask

    task automatic t_underflow();
        setfmt(0, 1, 0, 0, 8);
        irq_en = 1'b1;
        push(txw[0]); push(txw[1]);
        chk("R12 no irq before error", irq, 0);
        play(2);
        chk("R9 word L0", cap[0], txw[0]);
        chk("R9 word R0", cap[1], txw[1]);
        chk("R9 starved L1 zero", cap[2], 0);
        chk("R9 starved R1 zero", cap[3], 0);
        chk("R9 underflow flag", uf, 1);
        chk("R12 irq on flag", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R12 irq gated", irq, 0);
        irq_en = 1'b1;
        clear(2'b10);
        chk("R11 other mask keeps flag", uf, 1);
        clear(2'b01);
        chk("R11 flag cleared", uf, 0);
        chk("R12 irq falls", irq, 0);
    endtask

    task automatic t_rx();
        setfmt(1, 1, 1, 0, 8);
        rx_rd_en = 1'b1; @(negedge clk); rx_rd_en = 1'b0; @(negedge clk);
        chk("R7 busy after read", busy, 1);
        play(2);
        chk("R13 sdo quiet in receive", sdo_ones, 0);
        for (int i = 0; i < 4; i++) begin
            logic [23:0] w;
            pop(w);
            chk("R6 received word", w, rxw[i] & mask(24));
        end
        chk("R10 no overflow", of, 0);
    endtask

    task automatic t_rx_ovf();
        setfmt(1, 0, 0, 1, 0);
        rx_rd_en = 1'b1; @(negedge clk); rx_rd_en = 1'b0; @(negedge clk);
        play(3);
        chk("R10 overflow flag", of, 1);
        for (int i = 0; i < 4; i++) begin
            logic [23:0] w;
            pop(w);
            chk("R6/R10 kept word", w, rxw[i] & mask(16));
        end
        chk("R10 dropped words absent", rx_empty, 1);
        clear(2'b01);
        chk("R11 overflow kept by other mask", of, 1);
        clear(2'b10);
        chk("R11 overflow cleared", of, 0);
    endtask

    initial begin
        txw[0] = 24'hA5C3E1; txw[1] = 24'h5A3C1E; txw[2] = 24'hF0F00F; txw[3] = 24'h0FF0F1;
        txw[4] = 24'hAB1234; txw[5] = 24'hCD8001; txw[6] = 24'hEF7FFE; txw[7] = 24'h01C35A;
        rxw[0] = 24'h9A5B3C; rxw[1] = 24'h123456; rxw[2] = 24'h800001; rxw[3] = 24'h7FFFFE;
        rxw[4] = 24'hC0FFEE; rxw[5] = 24'h0BEEF0; rxw[6] = 24'h55AA55; rxw[7] = 24'hAA55AA;
        rst_n = 1'b0; bclk = 1'b1; fclk = 1'b1; sdi = 1'b0; port_en = 1'b0;
        cfg_rx = 1'b0; cfg_dly = 1'b0; cfg_inv = 1'b0; cfg_pol = 1'b0; cfg_code = '0;
        irq_en = 1'b0; tx_wr_en = 1'b0; tx_wr_data = '0; rx_rd_en = 1'b0;
        clr_wr = 1'b0; clr_bits = '0;
        t_tx_i2s();
        t_tx_lj();
        t_unsup();
        t_underflow();
        t_rx();
        t_rx_ovf();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule